// File: doc/BRIEF.md
# Two-Die Overlapped Block Erase Sequencer

This block erases a list of flash blocks spread over the two dies of a shared package. It keeps both dies busy at once. It issues the erase for the current block and only then selects the die that received the previous erase, waits for that die's erase-interrupt flag to rise, and reads the controller status to decide pass or fail. After the last request it makes one more status check on the die erased last.

Requests arrive one at a time on a valid/ready port. Each request carries a die bit, a block address and a flag that marks the final request of a list. The sequencer reaches the memory controller through a single register port: one access at a time, request held until acknowledge. A list ends with a one-cycle `done` pulse. If an erase fails, the sequencer raises a sticky `err` that reports the die and block of the failing erase, and it then stops until reset. It never writes the interrupt register, because the device clears that register by itself. It does not suspend or resume an erase.

Top module: `ilv_erase_seq`

## Requirements
- R1: After reset the outputs are as follows: `reg_req`=0, `done`=0, `err`=0 and `req_ready`=1.
- R2: For the first request of a list, the access order is as follows:
  - write 0xF101 with the die in bit 15 and zeros elsewhere;
  - read 0xF241 repeatedly until bit 15 reads 1;
  - write 0xF100 with the die in bit 15 and the block in the low bits;
  - write 0x0094 to 0xF220.
- R3: Every later request uses the same select, address and command writes, with no ready poll.
- R4: After the command write of a request, the sequencer checks the request before it, if that request is still unchecked. The check writes that request's die to 0xF101, then reads 0xF241 until bit 5 rises, then reads 0xF240.
- R5: A rise of bit 5 counts only if a read of 0 follows the command to that die and a read of 1 then follows it. A stale 1 read right after the command is not accepted.
- R6: If bit 10 of a 0xF240 read is 1, the following happens:
  - `err` rises and stays high until reset;
  - `err_die` and `err_blk` name the failing erase;
  - `req_ready` stays 0 and no further register access is made.
- R7: After the command for the request marked last, the final check runs on that die (select, edge wait, status read). If bit 10 is 0, `done` pulses for exactly one cycle and the block returns to idle with `req_ready`=1.
- R8: The sequencer never writes register 0xF241.
- R9: Only one register access is outstanding at a time. While `reg_req` is high without `reg_ack`, the address, write enable and write data hold steady.
- R10: A request is taken only on `req_valid` && `req_ready`. `req_ready` is never high while a register access is pending.
- R11: Two requests in a row may target the same die. The unchecked erase on that die is then fully checked before the new request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Erase request present |
| req_ready | output | 1 | Request accepted this cycle when valid |
| req_die | input | 1 | Target die |
| req_blk | input | BLK_W | Target block |
| req_last | input | 1 | Final request of the list |
| reg_req | output | 1 | Register access request |
| reg_we | output | 1 | 1 = write, 0 = read |
| reg_addr | output | 16 | Register address |
| reg_wdata | output | 16 | Write data |
| reg_ack | input | 1 | Access completes when high with reg_req |
| reg_rdata | input | 16 | Read data, valid with reg_ack |
| done | output | 1 | One-cycle pulse when a list passed |
| err | output | 1 | Sticky erase failure |
| err_die | output | 1 | Die of the failing erase |
| err_blk | output | BLK_W | Block of the failing erase |

## Verification
The status check of an earlier erase and the issue of a new one compete for the same register port. The sharpest collisions come from two cases: a request to the die whose erase is still unchecked (R11), and a stale interrupt bit left high while the other die is already erasing (R5). The bench sweeps every die pattern for lists of one to four requests, with an injected failure at each position, with and without stale flag reads, and with varied acknowledge latency. A memory model flags any status read made while a die is still busy, and the ordered log of writes and status reads is compared with a sequence computed in the bench.

// File: rtl/ilv_erase_seq.sv
module ilv_erase_seq #(
  parameter int BLK_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_die,
  input  logic [BLK_W-1:0] req_blk,
  input  logic             req_last,
  output logic             reg_req,
  output logic             reg_we,
  output logic [15:0]      reg_addr,
  output logic [15:0]      reg_wdata,
  input  logic             reg_ack,
  input  logic [15:0]      reg_rdata,
  output logic             done,
  output logic             err,
  output logic             err_die,
  output logic [BLK_W-1:0] err_blk
);
  localparam logic [15:0] A_ADDR = 16'hF100;
  localparam logic [15:0] A_SEL  = 16'hF101;
  localparam logic [15:0] A_CMD  = 16'hF220;
  localparam logic [15:0] A_STAT = 16'hF240;
  localparam logic [15:0] A_INT  = 16'hF241;
  localparam logic [15:0] V_ERASE = 16'h0094;

  typedef enum logic [3:0] {IDLE, SEL_CUR, POLL_RDY, WR_ADDR, WR_CMD,
                            SEL_CHK, WAIT_EI, RD_STAT, NEXT, HALT} st_t;
  typedef enum logic [1:0] {PH_PREV, PH_DRAIN, PH_FINAL} ph_t;

  st_t st;
  ph_t ph;
  logic             first, have_prev, cur_chk, cur_last;
  logic             cur_die, prev_die, chk_die;
  logic [BLK_W-1:0] cur_blk, prev_blk, chk_blk;
  logic [1:0]       ei_seen;

  wire fire = reg_req & reg_ack;
  wire take = req_valid & req_ready;
  wire ei_edge = ~ei_seen[chk_die] & reg_rdata[5];

  assign reg_req   = st inside {SEL_CUR, POLL_RDY, WR_ADDR, WR_CMD, SEL_CHK, WAIT_EI, RD_STAT};
  assign reg_we    = st inside {SEL_CUR, WR_ADDR, WR_CMD, SEL_CHK};
  assign req_ready = (st == IDLE) | ((st == NEXT) & ((req_die != cur_die) | cur_chk));

  always_comb begin
    reg_addr  = 16'h0000;
    reg_wdata = 16'h0000;
    case (st)
      SEL_CUR:  begin reg_addr = A_SEL;  reg_wdata = {cur_die, 15'h0}; end
      POLL_RDY: reg_addr = A_INT;
      WR_ADDR:  begin reg_addr = A_ADDR; reg_wdata = {cur_die, 15'(cur_blk)}; end
      WR_CMD:   begin reg_addr = A_CMD;  reg_wdata = V_ERASE; end
      SEL_CHK:  begin reg_addr = A_SEL;  reg_wdata = {chk_die, 15'h0}; end
      WAIT_EI:  reg_addr = A_INT;
      RD_STAT:  reg_addr = A_STAT;
      default:  ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= IDLE; ph <= PH_PREV;
      first <= 1'b0; have_prev <= 1'b0; cur_chk <= 1'b0; cur_last <= 1'b0;
      cur_die <= 1'b0; prev_die <= 1'b0; chk_die <= 1'b0;
      cur_blk <= '0; prev_blk <= '0; chk_blk <= '0;
      ei_seen <= 2'b11;
      done <= 1'b0; err <= 1'b0; err_die <= 1'b0; err_blk <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        IDLE: if (take) begin
          cur_die <= req_die; cur_blk <= req_blk; cur_last <= req_last;
          first <= 1'b1; have_prev <= 1'b0; cur_chk <= 1'b0;
          st <= SEL_CUR;
        end
        SEL_CUR:  if (fire) st <= first ? POLL_RDY : WR_ADDR;
        POLL_RDY: if (fire && reg_rdata[15]) st <= WR_ADDR;
        WR_ADDR:  if (fire) st <= WR_CMD;
        WR_CMD: if (fire) begin
          first <= 1'b0;
          ei_seen[cur_die] <= 1'b1;
          if (have_prev) begin
            chk_die <= prev_die; chk_blk <= prev_blk; ph <= PH_PREV; st <= SEL_CHK;
          end else if (cur_last) begin
            chk_die <= cur_die; chk_blk <= cur_blk; ph <= PH_FINAL; st <= SEL_CHK;
          end else st <= NEXT;
        end
        SEL_CHK: if (fire) st <= WAIT_EI;
        WAIT_EI: if (fire) begin
          ei_seen[chk_die] <= reg_rdata[5];
          if (ei_edge) st <= RD_STAT;
        end
        RD_STAT: if (fire) begin
          if (reg_rdata[10]) begin
            err <= 1'b1; err_die <= chk_die; err_blk <= chk_blk; st <= HALT;
          end else begin
            case (ph)
              PH_PREV: begin
                have_prev <= 1'b0;
                if (cur_last) begin
                  chk_die <= cur_die; chk_blk <= cur_blk; ph <= PH_FINAL; st <= SEL_CHK;
                end else st <= NEXT;
              end
              PH_DRAIN: begin cur_chk <= 1'b1; st <= NEXT; end
              default:  begin done <= 1'b1; st <= IDLE; end
            endcase
          end
        end
        NEXT: if (take) begin
          prev_die <= cur_die; prev_blk <= cur_blk; have_prev <= ~cur_chk;
          cur_die <= req_die; cur_blk <= req_blk; cur_last <= req_last;
          cur_chk <= 1'b0; st <= SEL_CUR;
        end else if (req_valid && !cur_chk) begin
          chk_die <= cur_die; chk_blk <= cur_blk; ph <= PH_DRAIN; st <= SEL_CHK;
        end
        default: ;
      endcase
    end
  end

  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    reg_req && !reg_ack |=> reg_req && $stable(reg_addr) && $stable(reg_we) && $stable(reg_wdata));
  a_r8_no_int_write: assert property (@(posedge clk) disable iff (!rst_n)
    reg_req && reg_we |-> reg_addr != A_INT);
  a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err && $stable(err_die) && $stable(err_blk));
  a_r6_halted: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !reg_req && !req_ready);
  a_r7_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r10_ready_idle: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !reg_req);
endmodule

// File: tb/sim_ilv_erase_seq.sv
`timescale 1ns/1ps
module sim_ilv_erase_seq;
  localparam int BW = 10;
  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_die = 0, req_last = 0;
  logic [BW-1:0] req_blk = '0;
  logic req_ready, reg_req, reg_we, reg_ack = 0;
  logic [15:0] reg_addr, reg_wdata, reg_rdata = 0;
  logic done, err, err_die;
  logic [BW-1:0] err_blk;

  always #2.5 clk = ~clk;

  ilv_erase_seq #(.BLK_W(BW)) u0 (.*);

  int total = 0, bad = 0;
  logic [32:0] exp_log [0:63];
  logic [32:0] got_log [0:63];
  int ne, ng;
  int busy [2], stale [2];
  bit failf [2];
  int sel, adie, rdy_left, cmd_k, fidx, stale_n, wait_n, wcnt;
  int rdy_reads, early, int_wr, hold_bad;
  bit seen_addr;
  logic [15:0] cap_addr, cap_wdata, first_addr;
  logic cap_we;

  task automatic chk(input bit ok, input string what, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, expv);
    end
  endtask

  task automatic model_step();
    if (reg_ack) begin
      if (cap_we) begin
        if (cap_addr == 16'hF241) int_wr++;
        if (cap_addr == 16'hF101) sel = int'(cap_wdata[15]);
        if (cap_addr == 16'hF100) begin adie = int'(cap_wdata[15]); seen_addr = 1; end
        if (cap_addr == 16'hF220) begin
          busy[adie] = 2 + (cmd_k % 2); stale[adie] = stale_n;
          failf[adie] = (cmd_k == fidx); cmd_k++;
        end
        if (ng < 64) got_log[ng] = {1'b1, cap_addr, cap_wdata};
        ng++;
      end
      reg_ack = 0; wcnt = 0;
    end
    if (reg_req && !reg_ack) begin
      if (wcnt == 0) first_addr = reg_addr;
      if (wcnt >= wait_n) begin
        if (reg_addr != first_addr) hold_bad++;
        cap_we = reg_we; cap_addr = reg_addr; cap_wdata = reg_wdata;
        reg_rdata = 16'h0;
        if (!reg_we && reg_addr == 16'hF241) begin
          if (!seen_addr) rdy_reads++;
          if (rdy_left > 0) rdy_left--; else reg_rdata[15] = 1;
          if (stale[sel] > 0) begin stale[sel]--; reg_rdata[5] = 1; end
          else if (busy[sel] > 0) busy[sel]--;
          else reg_rdata[5] = 1;
        end
        if (!reg_we && reg_addr == 16'hF240) begin
          if (busy[sel] != 0 || stale[sel] != 0) early++;
          reg_rdata[10] = failf[sel];
          if (ng < 64) got_log[ng] = {1'b0, 16'hF240, 16'h0};
          ng++;
        end
        reg_ack = 1;
      end else wcnt++;
    end
  endtask

  task automatic push(input logic [32:0] e);
    exp_log[ne] = e; ne++;
  endtask

  task automatic run(input int n, input int pat, input int fi, input int st_n, input int wt);
    int d [4];
    int b [4];
    bit stop, pend, exp_err, seen_done, seen_err;
    int xdie, xblk, fed, dcnt, extra, cyc, logbad, rdyhigh_busy;
    logic [32:0] ent;
    fidx = fi; stale_n = st_n; wait_n = wt;
    for (int i = 0; i < 4; i++) begin
      d[i] = (pat >> i) & 1;
      b[i] = (i * 97 + pat * 13 + 3) & 1023;
    end
    ne = 0; stop = 0; pend = 0; exp_err = 0; xdie = 0; xblk = 0;
    for (int i = 0; i < n && !stop; i++) begin
      if (i > 0 && d[i] == d[i-1] && pend) begin
        push({1'b1, 16'hF101, 16'(d[i-1] << 15)}); push({1'b0, 16'hF240, 16'h0});
        pend = 0;
        if (fi == i - 1) begin stop = 1; exp_err = 1; xdie = d[i-1]; xblk = b[i-1]; end
      end
      if (!stop) begin
        push({1'b1, 16'hF101, 16'(d[i] << 15)});
        push({1'b1, 16'hF100, 16'((d[i] << 15) | b[i])});
        push({1'b1, 16'hF220, 16'h0094});
        if (pend) begin
          push({1'b1, 16'hF101, 16'(d[i-1] << 15)}); push({1'b0, 16'hF240, 16'h0});
          if (fi == i - 1) begin stop = 1; exp_err = 1; xdie = d[i-1]; xblk = b[i-1]; end
        end
        pend = 1;
      end
    end
    if (!stop) begin
      push({1'b1, 16'hF101, 16'(d[n-1] << 15)}); push({1'b0, 16'hF240, 16'h0});
      if (fi == n - 1) begin exp_err = 1; xdie = d[n-1]; xblk = b[n-1]; end
    end
    busy[0] = 0; busy[1] = 0; stale[0] = 0; stale[1] = 0; failf[0] = 0; failf[1] = 0;
    sel = 0; adie = 0; rdy_left = 2; cmd_k = 0; wcnt = 0; ng = 0;
    rdy_reads = 0; early = 0; int_wr = 0; hold_bad = 0; seen_addr = 0;
    reg_ack = 0; req_valid = 0; rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!reg_req && !done && !err && req_ready, "R1 reset state", {reg_req, done, err, req_ready}, 1);
    fed = 0; pend = 0; dcnt = 0; extra = 0; cyc = 0; rdyhigh_busy = 0;
    seen_done = 0; seen_err = 0;
    while (extra < 8 && cyc < 3000) begin
      if (pend) fed++;
      model_step();
      if (done) begin dcnt++; seen_done = 1; end
      if (err) seen_err = 1;
      if (seen_err && (reg_req || req_ready)) rdyhigh_busy++;
      if (req_ready && reg_req) rdyhigh_busy++;
      req_valid = (fed < n) && !seen_done;
      req_die = d[fed < n ? fed : 0][0];
      req_blk = BW'(b[fed < n ? fed : 0]);
      req_last = (fed == n - 1);
      #1;
      pend = req_valid && req_ready;
      if (seen_done || seen_err) extra++;
      cyc++;
      @(negedge clk);
    end
    req_valid = 0;
    chk(cyc < 3000, "R7 run finished", cyc, 3000);
    logbad = (ng != ne) ? 1 : 0;
    for (int i = 0; i < ne && i < ng; i++) if (got_log[i] != exp_log[i]) logbad++;
    chk(logbad == 0, "R2 R3 R4 R11 access order", ng, ne);
    chk(rdy_reads == 3, "R2 ready poll count", rdy_reads, 3);
    chk(early == 0, "R5 status read before erase end", early, 0);
    chk(int_wr == 0, "R8 interrupt register write", int_wr, 0);
    chk(hold_bad == 0, "R9 request held stable", hold_bad, 0);
    if (exp_err) begin
      chk(err && dcnt == 0, "R6 error raised", {err, 1'(dcnt)}, 2);
      chk(err_die == xdie[0] && err_blk == BW'(xblk), "R6 failing die/block",
          {err_die, err_blk}, (xdie << BW) | xblk);
      chk(rdyhigh_busy == 0, "R6 halted after error", rdyhigh_busy, 0);
    end else begin
      chk(!err && dcnt == 1, "R7 single done pulse", dcnt, 1);
      chk(req_ready && !reg_req, "R7 back to idle", req_ready, 1);
      chk(fed == n && rdyhigh_busy == 0, "R10 requests taken", fed, n);
    end
  endtask

  initial begin
    #(5.0 * 190000);
    bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    for (int n = 1; n <= 4; n++)
      for (int pat = 0; pat < (1 << n); pat++)
        for (int fi = -1; fi < n; fi++)
          for (int s = 0; s < 2; s++)
            run(n, pat, fi, s, (pat + n + s) % 3);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule